// File: doc/BRIEF.md
# RV64 Integer ALU with Bit-Manipulation

This block is the integer arithmetic and logic unit of a 64-bit core's execute stage. Each cycle it can accept two 64-bit operands and an 8-bit operation code. One clock later it returns a 64-bit result and a flag that says whether a conditional branch is taken. Its operations cover:

- plain and inverted-operand logic;
- byte and halfword extension, per-byte OR-combine and byte reversal;
- signed and unsigned compare-select;
- add with a pre-scaled first operand, and subtract;
- logical and arithmetic shifts, and rotates;
- single-bit clear, set, invert and extract;
- leading-zero, trailing-zero and population counts.

Setting bit 7 of the operation code selects the 32-bit word form of an operation. A word form works on the low halves of the operands and sign-extends its 32-bit result.

The operation code is bit-sliced, so groups of operations can be decoded from fields. Bits 7:3 equal to 00010 mark a branch compare. In that case bits 2:1 choose the comparison and bit 0 inverts its outcome. Bits 7:3 equal to 00100 mark the add group. In that group bits 2:1 give the left shift of operand A and bit 0 zero-extends the low word of A first. The unit computes no branch target and does no instruction decode.

Top module: `int_alu`

## Requirements
- R1: `valid_o` rises one clock after `valid_i` is sampled high. `result_o` and `taken_o` are loaded only on a cycle where `valid_i` is high, and hold their values otherwise. An active-low asynchronous reset clears all three outputs.
- R2: Logic codes, where B' is ~B in the inverted forms:
  - 0x00 A&B, 0x02 A|B, 0x04 A^B;
  - 0x01 A&~B, 0x03 A|~B, 0x05 ~(A^B).
- R3: Extension and byte codes:
  - 0x08 sign-extends byte 0 and 0x09 sign-extends halfword 0;
  - 0x0A zero-extends halfword 0;
  - 0x0C sets each byte to 0xFF when any of its bits is set and to 0x00 otherwise;
  - 0x0D reverses the byte order.
- R4: Compare-select codes:
  - 0x18 gives signed A<B as 0 or 1, and 0x1A gives unsigned A<B as 0 or 1;
  - 0x1C signed max, 0x1D signed min;
  - 0x1E unsigned max, 0x1F unsigned min.
- R5: Codes 0x10, 0x11, 0x14, 0x15, 0x16 and 0x17 are branches. Bits 2:1 pick the comparison: 00 equal, 10 signed less-than, 11 unsigned less-than. Bit 0 inverts the outcome. A branch returns a zero result. `taken_o` is 0 for every non-branch code.
- R6: Codes 0x20 to 0x27 return (A' << op[2:1]) + B. Here A' is A zero-extended from its low 32 bits when op[0] is 1, and A otherwise. Code 0x28 returns A-B.
- R7: Shift and rotate codes take the shift amount from B[5:0]:
  - 0x40 shift left, 0x41 shift left of A zero-extended from 32 bits;
  - 0x4A logical right, 0x4B arithmetic right;
  - 0x50 rotate left, 0x58 rotate right.
- R8: Single-bit codes take the bit index from B[5:0]. 0x44 clears the bit, 0x45 inverts it and 0x46 sets it. 0x47 returns the bit in result bit 0, with all other bits zero.
- R9: Code 0x60 counts leading zeros, 0x61 counts trailing zeros and 0x62 counts set bits. A zero input gives 64 for both zero counts.
- R10: Word codes compute on the low 32 bits, take shift amounts from B[4:0] and sign-extend the 32-bit result:
  - 0xA0 add, 0xA8 subtract;
  - 0xC0 shift left, 0xCA logical right, 0xCB arithmetic right;
  - 0xD0 rotate left, 0xD8 rotate right;
  - 0xE0 leading zeros, 0xE1 trailing zeros, 0xE2 set bits.

  A zero low word gives 32 for both word zero counts.
- R11: Any other code (for example 0x07, 0x12 or 0x90) gives a zero result with `taken_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and code are valid this cycle |
| op_i | input | 8 | Operation code |
| src_a_i | input | 64 | Operand A |
| src_b_i | input | 64 | Operand B |
| valid_o | output | 1 | Result is valid |
| result_o | output | 64 | Result |
| taken_o | output | 1 | Branch compare outcome |

## Verification
The bench targets the corners where a near-miss design stays plausible:

- **Rotate by zero.** A rotate whose complementary shift is not handled returns zero or garbage instead of the operand.
- **Zero counts of zero.** A count that falls out of the scan on a zero input reports 63 or 0 instead of 64 or 32.
- **Signed versus unsigned.** With -1 against 1, a signed/unsigned mix-up flips min, max, the set-less-than results and the branch outcomes.
- **Word results with bit 31 set.** These must come back sign-extended, not zero-extended.
- **Index bits above the legal range.** These must not disturb shifts and bit operations.
- **Unused codes next to legal ones.** Codes such as 0x12 and 0x90 sit beside legal ones and must yield zero. A decoder that matched only a field would return compare results for them.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned XLEN = 64;
  typedef logic [7:0] alu_op_t;

  localparam alu_op_t OP_AND   = 8'h00, OP_ANDN  = 8'h01, OP_OR    = 8'h02, OP_ORN  = 8'h03;
  localparam alu_op_t OP_XOR   = 8'h04, OP_XNOR  = 8'h05;
  localparam alu_op_t OP_SEXTB = 8'h08, OP_SEXTH = 8'h09, OP_ZEXTH = 8'h0A;
  localparam alu_op_t OP_ORCB  = 8'h0C, OP_REV8  = 8'h0D;
  localparam alu_op_t OP_SLT   = 8'h18, OP_SLTU  = 8'h1A, OP_MAX   = 8'h1C, OP_MIN  = 8'h1D;
  localparam alu_op_t OP_MAXU  = 8'h1E, OP_MINU  = 8'h1F;
  localparam alu_op_t OP_SUB   = 8'h28;
  localparam alu_op_t OP_SLL   = 8'h40, OP_SLLIUW = 8'h41, OP_BCLR = 8'h44, OP_BINV = 8'h45;
  localparam alu_op_t OP_BSET  = 8'h46, OP_BEXT  = 8'h47, OP_SRL   = 8'h4A, OP_SRA  = 8'h4B;
  localparam alu_op_t OP_ROL   = 8'h50, OP_ROR   = 8'h58;
  localparam alu_op_t OP_CLZ   = 8'h60, OP_CTZ   = 8'h61, OP_CPOP  = 8'h62;
  localparam alu_op_t OP_ADDW  = 8'hA0, OP_SUBW  = 8'hA8, OP_SLLW  = 8'hC0, OP_SRLW = 8'hCA;
  localparam alu_op_t OP_SRAW  = 8'hCB, OP_ROLW  = 8'hD0, OP_RORW  = 8'hD8;
  localparam alu_op_t OP_CLZW  = 8'hE0, OP_CTZW  = 8'hE1, OP_CPOPW = 8'hE2;

  // field patterns of op[7:3]
  localparam logic [4:0] GRP_BRANCH = 5'b00010;
  localparam logic [4:0] GRP_ADD    = 5'b00100;

  // compare selector op[2:1] inside the branch group
  localparam logic [1:0] CMP_EQ  = 2'b00;
  localparam logic [1:0] CMP_LT  = 2'b10;
  localparam logic [1:0] CMP_LTU = 2'b11;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  alu_op_t           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              taken_o,
  output logic              hit_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] orc_w, rev_w;
  logic              lt_s, lt_u, eq, cmp_raw, is_branch;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign orc_w[8*g +: 8] = {8{|a_i[8*g +: 8]}};
    assign rev_w[8*g +: 8] = a_i[8*(NBYTES-1-g) +: 8];
  end

  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;
  assign eq   = a_i == b_i;

  always_comb begin
    unique case (op_i[2:1])
      CMP_EQ:  cmp_raw = eq;
      CMP_LT:  cmp_raw = lt_s;
      CMP_LTU: cmp_raw = lt_u;
      default: cmp_raw = 1'b0;
    endcase
  end

  // selector 01 is unassigned, so 0x12/0x13 are not branches
  assign is_branch = (op_i[7:3] == GRP_BRANCH) && (op_i[2:1] != 2'b01);

  always_comb begin
    res_o   = '0;
    taken_o = 1'b0;
    hit_o   = 1'b1;
    if (is_branch) begin
      taken_o = cmp_raw ^ op_i[0];
    end else begin
      case (op_i)
        OP_AND:   res_o = a_i & b_i;
        OP_ANDN:  res_o = a_i & ~b_i;
        OP_OR:    res_o = a_i | b_i;
        OP_ORN:   res_o = a_i | ~b_i;
        OP_XOR:   res_o = a_i ^ b_i;
        OP_XNOR:  res_o = ~(a_i ^ b_i);
        OP_SEXTB: res_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
        OP_SEXTH: res_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
        OP_ZEXTH: res_o = {{(DATA_W-16){1'b0}}, a_i[15:0]};
        OP_ORCB:  res_o = orc_w;
        OP_REV8:  res_o = rev_w;
        OP_SLT:   res_o = {{(DATA_W-1){1'b0}}, lt_s};
        OP_SLTU:  res_o = {{(DATA_W-1){1'b0}}, lt_u};
        OP_MAX:   res_o = lt_s ? b_i : a_i;
        OP_MIN:   res_o = lt_s ? a_i : b_i;
        OP_MAXU:  res_o = lt_u ? b_i : a_i;
        OP_MINU:  res_o = lt_u ? a_i : b_i;
        default:  hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_shift_add_unit.sv
module alu_shift_add_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  alu_op_t           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              hit_o
);
  localparam int unsigned HALF  = DATA_W / 2;
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned HSH_W = $clog2(HALF);
  localparam logic [SH_W:0]  FULL_AMT = DATA_W[SH_W:0];
  localparam logic [HSH_W:0] HALF_AMT = HALF[HSH_W:0];

  function automatic logic [DATA_W-1:0] sext_w(input logic [HALF-1:0] v);
    return {{HALF{v[HALF-1]}}, v};
  endfunction

  logic [SH_W-1:0]   sh;
  logic [HSH_W-1:0]  shw;
  logic [SH_W:0]     sh_rev;
  logic [HSH_W:0]    shw_rev;
  logic [HALF-1:0]   a_lo, b_lo;
  logic [DATA_W-1:0] a_uw, a_pre, one_hot;

  assign sh      = b_i[SH_W-1:0];
  assign shw     = b_i[HSH_W-1:0];
  assign sh_rev  = FULL_AMT - {1'b0, sh};
  assign shw_rev = HALF_AMT - {1'b0, shw};
  assign a_lo    = a_i[HALF-1:0];
  assign b_lo    = b_i[HALF-1:0];
  assign a_uw    = {{HALF{1'b0}}, a_lo};
  assign a_pre   = op_i[0] ? a_uw : a_i;
  assign one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << sh;

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    if (op_i[7:3] == GRP_ADD) begin
      res_o = (a_pre << op_i[2:1]) + b_i;
    end else begin
      case (op_i)
        OP_SUB:    res_o = a_i - b_i;
        OP_SLL:    res_o = a_i << sh;
        OP_SLLIUW: res_o = a_uw << sh;
        OP_BCLR:   res_o = a_i & ~one_hot;
        OP_BINV:   res_o = a_i ^ one_hot;
        OP_BSET:   res_o = a_i | one_hot;
        OP_BEXT:   res_o = {{(DATA_W-1){1'b0}}, a_i[sh]};
        OP_SRL:    res_o = a_i >> sh;
        OP_SRA:    res_o = $signed(a_i) >>> sh;
        OP_ROL:    res_o = (a_i << sh) | (a_i >> sh_rev);
        OP_ROR:    res_o = (a_i >> sh) | (a_i << sh_rev);
        OP_ADDW:   res_o = sext_w(a_lo + b_lo);
        OP_SUBW:   res_o = sext_w(a_lo - b_lo);
        OP_SLLW:   res_o = sext_w(a_lo << shw);
        OP_SRLW:   res_o = sext_w(a_lo >> shw);
        OP_SRAW:   res_o = sext_w($signed(a_lo) >>> shw);
        OP_ROLW:   res_o = sext_w((a_lo << shw) | (a_lo >> shw_rev));
        OP_RORW:   res_o = sext_w((a_lo >> shw) | (a_lo << shw_rev));
        default:   hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_count_unit.sv
module alu_count_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  alu_op_t           op_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output logic              hit_o
);
  localparam int unsigned HALF  = DATA_W / 2;
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] lz_in, tz_in, pc_in;
  logic [CNT_W-1:0]  lz_cnt, tz_cnt, pc_cnt;
  logic              word;

  assign word = op_i[7];
  // a sentinel bit below/above the low word caps word counts at HALF
  assign lz_in = word ? {a_i[HALF-1:0], 1'b1, {(HALF-1){1'b0}}} : a_i;
  assign tz_in = word ? {{(HALF-1){1'b0}}, 1'b1, a_i[HALF-1:0]} : a_i;
  assign pc_in = word ? {{HALF{1'b0}}, a_i[HALF-1:0]} : a_i;

  always_comb begin
    lz_cnt = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++)
      if (lz_in[i]) lz_cnt = CNT_W'(DATA_W - 1 - i);
  end

  always_comb begin
    tz_cnt = CNT_W'(DATA_W);
    for (int i = DATA_W - 1; i >= 0; i--)
      if (tz_in[i]) tz_cnt = CNT_W'(i);
  end

  always_comb begin
    pc_cnt = '0;
    for (int i = 0; i < DATA_W; i++)
      pc_cnt = pc_cnt + CNT_W'(pc_in[i]);
  end

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    case (op_i)
      OP_CLZ,  OP_CLZW:  res_o = {{(DATA_W-CNT_W){1'b0}}, lz_cnt};
      OP_CTZ,  OP_CTZW:  res_o = {{(DATA_W-CNT_W){1'b0}}, tz_cnt};
      OP_CPOP, OP_CPOPW: res_o = {{(DATA_W-CNT_W){1'b0}}, pc_cnt};
      default:           hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              taken_o
);
  logic [DATA_W-1:0] lg_res, sa_res, ct_res, nxt_res;
  logic              lg_hit, sa_hit, ct_hit, lg_taken;

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .op_i(op_i), .a_i(src_a_i), .b_i(src_b_i),
    .res_o(lg_res), .taken_o(lg_taken), .hit_o(lg_hit)
  );

  alu_shift_add_unit #(.DATA_W(DATA_W)) u_shift_add (
    .op_i(op_i), .a_i(src_a_i), .b_i(src_b_i),
    .res_o(sa_res), .hit_o(sa_hit)
  );

  alu_count_unit #(.DATA_W(DATA_W)) u_count (
    .op_i(op_i), .a_i(src_a_i),
    .res_o(ct_res), .hit_o(ct_hit)
  );

  // unit decodes are disjoint; no hit means an unused code
  always_comb begin
    if (lg_hit)      nxt_res = lg_res;
    else if (sa_hit) nxt_res = sa_res;
    else if (ct_hit) nxt_res = ct_res;
    else             nxt_res = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      taken_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= nxt_res;
        taken_o  <= lg_taken;
      end
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        op_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              taken_o
);
  localparam int unsigned HALF = DATA_W / 2;

  assert_valid_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(taken_o)));

  assert_no_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[7:3] != 5'b00010) |=> !taken_o);

  assert_bext_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 8'h47) |=> (result_o[DATA_W-1:1] == '0));

  assert_count_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[7:2] == 6'b011000) |=> (result_o <= DATA_W));

  assert_word_sext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[7]) |=> (result_o[DATA_W-1:HALF] == {HALF{result_o[HALF-1]}}));
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_int_alu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .valid_o(valid_o), .result_o(result_o), .taken_o(taken_o)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
  localparam int NV = 59;
  // {req[3:0], op[7:0], a[63:0], b[63:0], expected[63:0], taken}
  localparam logic [204:0] VEC [NV] = '{
    {4'd2,  8'h00, 64'h000000000000F0F0, 64'h000000000000FF00, 64'h000000000000F000, 1'b0}, // R2 and
    {4'd2,  8'h01, 64'h000000000000F0F0, 64'h000000000000FF00, 64'h00000000000000F0, 1'b0}, // R2 andn
    {4'd2,  8'h02, 64'h000000000000F0F0, 64'h000000000000FF00, 64'h000000000000FFF0, 1'b0},
    {4'd2,  8'h03, 64'h0000000000000000, 64'hFFFFFFFFFFFFFF00, 64'h00000000000000FF, 1'b0},
    {4'd2,  8'h04, 64'h000000000000F0F0, 64'h000000000000FF00, 64'h0000000000000FF0, 1'b0},
    {4'd2,  8'h05, 64'h0000000000000000, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    {4'd3,  8'h08, 64'h0000000000000080, 64'h0000000000000000, 64'hFFFFFFFFFFFFFF80, 1'b0}, // R3
    {4'd3,  8'h09, 64'h0000000012347FFF, 64'h0000000000000000, 64'h0000000000007FFF, 1'b0},
    {4'd3,  8'h0A, 64'hFFFFFFFFFFFF8001, 64'h0000000000000000, 64'h0000000000008001, 1'b0},
    {4'd3,  8'h0C, 64'h0100000000001000, 64'h0000000000000000, 64'hFF0000000000FF00, 1'b0},
    {4'd3,  8'h0D, 64'h0102030405060708, 64'h0000000000000000, 64'h0807060504030201, 1'b0},
    {4'd4,  8'h18, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000001, 1'b0}, // R4
    {4'd4,  8'h1A, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 1'b0},
    {4'd4,  8'h1C, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000001, 1'b0},
    {4'd4,  8'h1D, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    {4'd4,  8'h1E, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    {4'd4,  8'h1F, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000001, 1'b0},
    {4'd5,  8'h10, 64'h0000000000000005, 64'h0000000000000005, 64'h0000000000000000, 1'b1}, // R5
    {4'd5,  8'h11, 64'h0000000000000005, 64'h0000000000000005, 64'h0000000000000000, 1'b0},
    {4'd5,  8'h14, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 1'b1},
    {4'd5,  8'h15, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 1'b0},
    {4'd5,  8'h16, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 1'b0},
    {4'd5,  8'h17, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 1'b1},
    {4'd6,  8'h20, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000002, 64'h0000000000000001, 1'b0}, // R6
    {4'd6,  8'h21, 64'hFFFFFFFF00000010, 64'h0000000000000001, 64'h0000000000000011, 1'b0},
    {4'd6,  8'h22, 64'h0000000000000003, 64'h0000000000000100, 64'h0000000000000106, 1'b0},
    {4'd6,  8'h25, 64'hFFFFFFFF80000000, 64'h0000000000000000, 64'h0000000200000000, 1'b0},
    {4'd6,  8'h26, 64'h0000000000000001, 64'h0000000000000001, 64'h0000000000000009, 1'b0},
    {4'd6,  8'h28, 64'h0000000000000000, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    {4'd7,  8'h40, 64'h0000000000000001, 64'h0000000000000043, 64'h0000000000000008, 1'b0}, // R7
    {4'd7,  8'h41, 64'hFFFFFFFF00000001, 64'h0000000000000020, 64'h0000000100000000, 1'b0},
    {4'd7,  8'h4A, 64'h8000000000000000, 64'h000000000000003F, 64'h0000000000000001, 1'b0},
    {4'd7,  8'h4B, 64'h8000000000000000, 64'h0000000000000004, 64'hF800000000000000, 1'b0},
    {4'd7,  8'h50, 64'h8000000000000001, 64'h0000000000000001, 64'h0000000000000003, 1'b0},
    {4'd7,  8'h58, 64'h0000000000000001, 64'h0000000000000001, 64'h8000000000000000, 1'b0},
    {4'd7,  8'h50, 64'h0000000000001234, 64'h0000000000000040, 64'h0000000000001234, 1'b0}, // R7 rotate by 0
    {4'd8,  8'h44, 64'h00000000000000FF, 64'h0000000000000003, 64'h00000000000000F7, 1'b0}, // R8
    {4'd8,  8'h45, 64'h0000000000000000, 64'h000000000000003F, 64'h8000000000000000, 1'b0},
    {4'd8,  8'h46, 64'h0000000000000000, 64'h0000000000000041, 64'h0000000000000002, 1'b0},
    {4'd8,  8'h47, 64'h8000000000000000, 64'h000000000000003F, 64'h0000000000000001, 1'b0},
    {4'd9,  8'h60, 64'h0000000000010000, 64'h0000000000000000, 64'h000000000000002F, 1'b0}, // R9
    {4'd9,  8'h60, 64'h0000000000000000, 64'h0000000000000000, 64'h0000000000000040, 1'b0},
    {4'd9,  8'h61, 64'h0000000000000100, 64'h0000000000000000, 64'h0000000000000008, 1'b0},
    {4'd9,  8'h61, 64'h0000000000000000, 64'h0000000000000000, 64'h0000000000000040, 1'b0},
    {4'd9,  8'h62, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'h0000000000000040, 1'b0},
    {4'd10, 8'hA0, 64'h000000007FFFFFFF, 64'h0000000000000001, 64'hFFFFFFFF80000000, 1'b0}, // R10
    {4'd10, 8'hA8, 64'h0000000100000000, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    {4'd10, 8'hC0, 64'h0000000000000001, 64'h000000000000003F, 64'hFFFFFFFF80000000, 1'b0},
    {4'd10, 8'hCA, 64'hFFFFFFFF80000000, 64'h000000000000001F, 64'h0000000000000001, 1'b0},
    {4'd10, 8'hCB, 64'h0000000080000000, 64'h0000000000000004, 64'hFFFFFFFFF8000000, 1'b0},
    {4'd10, 8'hD0, 64'h0000000080000001, 64'h0000000000000001, 64'h0000000000000003, 1'b0},
    {4'd10, 8'hD8, 64'h0000000000000001, 64'h0000000000000001, 64'hFFFFFFFF80000000, 1'b0},
    {4'd10, 8'hE0, 64'hFFFFFFFF00000000, 64'h0000000000000000, 64'h0000000000000020, 1'b0},
    {4'd10, 8'hE1, 64'hFFFFFFFF00000000, 64'h0000000000000000, 64'h0000000000000020, 1'b0},
    {4'd10, 8'hE2, 64'hFFFFFFFF0000000F, 64'h0000000000000000, 64'h0000000000000004, 1'b0},
    {4'd10, 8'hE0, 64'h0000000000000001, 64'h0000000000000000, 64'h000000000000001F, 1'b0},
    {4'd11, 8'h12, 64'h0000000000000005, 64'h0000000000000005, 64'h0000000000000000, 1'b0}, // R11
    {4'd11, 8'h07, 64'h00000000000000FF, 64'h0000000000000001, 64'h0000000000000000, 1'b0},
    {4'd11, 8'h90, 64'h0000000000000005, 64'h0000000000000005, 64'h0000000000000000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [7:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic        valid_out, taken;
  logic [63:0] result;
  int          n_chk = 0, n_fail = 0, cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  int_alu u_int_alu (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .op_i(op),
    .src_a_i(a), .src_b_i(b), .valid_o(valid_out), .result_o(result), .taken_o(taken)
  );

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {valid_out, result}, 65'd0);
    check("R1 reset taken", {64'd0, taken}, 65'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][200:193];
      a  = VEC[i][192:129];
      b  = VEC[i][128:65];
      valid_in = 1'b1;
      @(negedge clk);
      if ({result, taken} !== VEC[i][64:0]) begin
        n_fail++;
        $display("FAIL R%0d op=%h act=%h/%b exp=%h/%b", VEC[i][204:201], op,
                 result, taken, VEC[i][64:1], VEC[i][0]);
      end
      n_chk++;
    end
    check("R1 valid out", {64'd0, valid_out}, 65'd1);

    // R1 hold: load a taken branch, then idle with a different op on the inputs
    op = 8'h10; a = 64'd9; b = 64'd9; valid_in = 1'b1;
    @(negedge clk);
    check("R5 beq taken", {result, taken}, {64'd0, 1'b1});
    op = 8'h02; a = 64'hFF; b = 64'hFF00; valid_in = 1'b0;
    @(negedge clk);
    check("R1 idle valid", {64'd0, valid_out}, 65'd0);
    check("R1 idle hold", {result, taken}, {64'd0, 1'b1});
    valid_in = 1'b1;
    @(negedge clk);
    check("R1 resume", {result, valid_out}, {64'h000000000000FFFF, 1'b1});
    check("R5 non-branch clears taken", {64'd0, taken}, 65'd0);

    // R1 asynchronous reset mid-stream
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async reset", {result, valid_out}, 65'd0);
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
  end
endmodule